// File: doc/BRIEF.md
# Random Segment-Reversal Mutation Engine

This block mutates one candidate tour of a genetic search for a travelling-salesman style problem. The tour sits in a local array of 7-bit node identifiers, one per position in visiting order. A host loads and reads the array through a simple word port while the engine is idle, then strobes `start_i` with the live tour length.

On each accepted start a 16-bit pseudo-random shift register makes one draw to decide whether this tour mutates. The default odds are about one in a hundred. When the tour mutates, two more draws choose two cut positions. The engine then reverses the segment between those positions in place. It swaps the two outer ends, steps both indices inward and repeats until they meet.

A one-cycle `done_o` pulse closes every run, whether or not the tour changed. `mutated_o` tells the host whether any reversal took place. Crossover and tour cost are handled elsewhere.

Top module: `inv_mut_unit`

## Requirements
- R1: After reset `busy_o`, `done_o` and `mutated_o` are low, and the random register holds the nonzero parameter `SEED` (default 16'hACE1).
- R2: The random register is 16 bits. Each step maps s to {s[14:0], s[15]^s[13]^s[12]^s[10]}. It steps exactly once per draw and at no other time.
- R3: An accepted start makes one decision draw, and the first value after the step is examined. A mutation is attempted only if that value is below `MUT_THRESH` (default 655, about 1%) and the effective length is at least 2. Otherwise no further draws occur, the tour is untouched and `mutated_o` is 0.
- R4: The effective length is `len_i` latched at the accepted start and clamped to `MAX_NODES`.
- R5: An attempted mutation makes two further draws, A then B. Each is reduced modulo the effective length. lo = min(A mod L, B mod L) and hi = the max. If lo equals hi, the tour is unchanged and `mutated_o` is 0.
- R6: If lo < hi, positions lo..hi end up in reversed order, every other position keeps its value, and `mutated_o` is 1.
- R7: `done_o` is high for exactly one cycle. Count rising edges after the edge that accepts start, up to and including the edge after which `done_o` is high. That count is 1 when no mutation is attempted, 3 when the cuts are equal, and 3+4k for k = (hi-lo+1)/2 swaps (integer division).
- R8: While idle, a host write stores `acc_wdata_i` at `acc_addr_i`, and `acc_rdata_o` always shows the entry at `acc_addr_i`. While busy, host writes and `start_i` are ignored.
- R9: `busy_o` rises after the accepting edge, stays high through the `done_o` cycle and is low in the cycle after it.
- R10: `mutated_o` keeps its value from the end of a run until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| len_i | input | $clog2(MAX_NODES+1) | Live tour length |
| acc_we_i | input | 1 | Host write enable |
| acc_addr_i | input | $clog2(MAX_NODES) | Host word address |
| acc_wdata_i | input | NODE_W | Host write data |
| acc_rdata_o | output | NODE_W | Entry at `acc_addr_i` |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| mutated_o | output | 1 | Last run reversed a segment |

## Verification
Runs use many tour lengths: two, odd and even small lengths, one under the array size, the full size, lengths above it that must clamp, and lengths of 0 and 1 that must never attempt a change. The threshold is raised so that attempted and skipped runs both occur often. The tour contents differ from run to run, so a reversal with a wrong end or an off-by-one stop shows up as a mismatched entry. The bench carries its own model of the random sequence across all runs. An extra or missing step anywhere therefore shifts every later cut pair and latency. A directed run writes and strobes start while busy, to show that neither reaches the array or the random sequence.

// File: rtl/inv_mut_pkg.sv
package inv_mut_pkg;

   localparam int RNG_W = 16;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DECIDE,
      ST_CUT_A,
      ST_CUT_B,
      ST_RD_LO,
      ST_RD_HI,
      ST_WR_LO,
      ST_WR_HI,
      ST_DONE
   } mut_state_e;

   // Fibonacci form, feedback from bits 16,14,13,11 (one-based)
   function automatic logic [RNG_W-1:0] rng_advance(input logic [RNG_W-1:0] s);
      return {s[RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

endpackage

// File: rtl/inv_mut_lfsr.sv
module inv_mut_lfsr
   import inv_mut_pkg::*;
#(
   parameter logic [RNG_W-1:0] SEED = 16'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   output logic [RNG_W-1:0] value_o
);

   if (SEED == '0) begin : g_bad_seed
      $error("inv_mut_lfsr: SEED must be nonzero");
   end

   logic [RNG_W-1:0] state_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      state_q <= SEED;
      else if (step_i) state_q <= rng_advance(state_q);
   end

   assign value_o = state_q;

   // R2
   rng_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);

   // R2
   rng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(state_q));

endmodule

// File: rtl/inv_mut_store.sv
module inv_mut_store #(
   parameter int DEPTH  = 128,
   parameter int DATA_W = 7
) (
   input  logic                     clk,
   input  logic                     we_i,
   input  logic [$clog2(DEPTH)-1:0] waddr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic [$clog2(DEPTH)-1:0] raddr_a_i,
   output logic [DATA_W-1:0]        rdata_a_o,
   input  logic [$clog2(DEPTH)-1:0] raddr_b_i,
   output logic [DATA_W-1:0]        rdata_b_o
);

   localparam int ADDR_W = $clog2(DEPTH);

   if ((1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("inv_mut_store: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] rows [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_row
      logic [DATA_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (we_i && waddr_i == ADDR_W'(g)) cell_q <= wdata_i;
      end
      assign rows[g] = cell_q;
   end

   assign rdata_a_o = rows[raddr_a_i];
   assign rdata_b_o = rows[raddr_b_i];

endmodule

// File: rtl/inv_mut_ctrl.sv
module inv_mut_ctrl
   import inv_mut_pkg::*;
#(
   parameter int          MAX_NODES  = 128,
   parameter int          NODE_W     = 7,
   parameter int unsigned MUT_THRESH = 655
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic [$clog2(MAX_NODES+1)-1:0] len_i,
   input  logic [RNG_W-1:0]               rnd_i,
   output logic                           step_o,
   output logic [$clog2(MAX_NODES)-1:0]   eng_addr_o,
   input  logic [NODE_W-1:0]              eng_rdata_i,
   output logic                           eng_we_o,
   output logic [NODE_W-1:0]              eng_wdata_o,
   output logic                           busy_o,
   output logic                           done_o,
   output logic                           mutated_o
);

   localparam int IDX_W = $clog2(MAX_NODES);
   localparam int LEN_W = $clog2(MAX_NODES+1);
   localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_NODES);
   localparam logic [LEN_W-1:0] ONE     = LEN_W'(1);

   mut_state_e        state_q;
   logic [LEN_W-1:0]  len_q, cut_a_q, lo_q, hi_q;
   logic [NODE_W-1:0] hold_lo_q, hold_hi_q;
   logic              mut_q;

   logic [LEN_W-1:0] len_eff, rem_w, lo_w, hi_w;
   logic             attempt, in_swap;

   assign len_eff = (len_i > LEN_MAX) ? LEN_MAX : len_i;
   assign rem_w   = LEN_W'(rnd_i % RNG_W'(len_q));
   assign lo_w    = (cut_a_q < rem_w) ? cut_a_q : rem_w;
   assign hi_w    = (cut_a_q < rem_w) ? rem_w : cut_a_q;
   assign attempt = (len_q >= LEN_W'(2)) && (32'(rnd_i) < MUT_THRESH);
   assign in_swap = state_q inside {ST_RD_LO, ST_RD_HI, ST_WR_LO, ST_WR_HI};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         len_q     <= '0;
         cut_a_q   <= '0;
         lo_q      <= '0;
         hi_q      <= '0;
         hold_lo_q <= '0;
         hold_hi_q <= '0;
         mut_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               len_q   <= len_eff;
               mut_q   <= 1'b0;
               state_q <= ST_DECIDE;
            end
            ST_DECIDE: state_q <= attempt ? ST_CUT_A : ST_DONE;
            ST_CUT_A: begin
               cut_a_q <= rem_w;
               state_q <= ST_CUT_B;
            end
            ST_CUT_B: begin
               lo_q <= lo_w;
               hi_q <= hi_w;
               if (lo_w == hi_w) state_q <= ST_DONE;
               else begin
                  mut_q   <= 1'b1;
                  state_q <= ST_RD_LO;
               end
            end
            ST_RD_LO: begin
               hold_lo_q <= eng_rdata_i;
               state_q   <= ST_RD_HI;
            end
            ST_RD_HI: begin
               hold_hi_q <= eng_rdata_i;
               state_q   <= ST_WR_LO;
            end
            ST_WR_LO: state_q <= ST_WR_HI;
            ST_WR_HI: begin
               lo_q    <= lo_q + ONE;
               hi_q    <= hi_q - ONE;
               state_q <= ((lo_q + ONE) >= (hi_q - ONE)) ? ST_DONE : ST_RD_LO;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign step_o = (state_q == ST_IDLE && start_i) ||
                   (state_q == ST_DECIDE && attempt) ||
                   (state_q == ST_CUT_A);

   assign eng_addr_o  = (state_q == ST_RD_HI || state_q == ST_WR_HI) ?
                        hi_q[IDX_W-1:0] : lo_q[IDX_W-1:0];
   assign eng_we_o    = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
   assign eng_wdata_o = (state_q == ST_WR_LO) ? hold_hi_q : hold_lo_q;

   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = (state_q == ST_DONE);
   assign mutated_o = mut_q;

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   swap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_swap |-> (lo_q < hi_q));

   // R5
   cut_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_swap |-> (hi_q < len_q));

   // R9
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);

   // R10
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(mutated_o));

endmodule

// File: rtl/inv_mut_unit.sv
module inv_mut_unit
   import inv_mut_pkg::*;
#(
   parameter int               MAX_NODES  = 128,
   parameter int               NODE_W     = 7,
   parameter logic [RNG_W-1:0] SEED       = 16'hACE1,
   parameter int unsigned      MUT_THRESH = 655
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic [$clog2(MAX_NODES+1)-1:0] len_i,
   input  logic                           acc_we_i,
   input  logic [$clog2(MAX_NODES)-1:0]   acc_addr_i,
   input  logic [NODE_W-1:0]              acc_wdata_i,
   output logic [NODE_W-1:0]              acc_rdata_o,
   output logic                           busy_o,
   output logic                           done_o,
   output logic                           mutated_o
);

   localparam int IDX_W = $clog2(MAX_NODES);

   if (MAX_NODES < 2 || MAX_NODES > 32768) begin : g_bad_size
      $error("inv_mut_unit: MAX_NODES out of range");
   end
   if (MUT_THRESH > 65536) begin : g_bad_thresh
      $error("inv_mut_unit: MUT_THRESH above random range");
   end
   if (NODE_W < IDX_W) begin : g_bad_node_w
      $error("inv_mut_unit: NODE_W too narrow for MAX_NODES identifiers");
   end

   logic [RNG_W-1:0]  rnd;
   logic              step;
   logic [IDX_W-1:0]  eng_addr;
   logic [NODE_W-1:0] eng_rdata, eng_wdata;
   logic              eng_we;

   logic              st_we;
   logic [IDX_W-1:0]  st_waddr;
   logic [NODE_W-1:0] st_wdata;

   inv_mut_lfsr #(.SEED(SEED)) u_rng (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (step),
      .value_o (rnd)
   );

   inv_mut_ctrl #(
      .MAX_NODES  (MAX_NODES),
      .NODE_W     (NODE_W),
      .MUT_THRESH (MUT_THRESH)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .len_i       (len_i),
      .rnd_i       (rnd),
      .step_o      (step),
      .eng_addr_o  (eng_addr),
      .eng_rdata_i (eng_rdata),
      .eng_we_o    (eng_we),
      .eng_wdata_o (eng_wdata),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .mutated_o   (mutated_o)
   );

   // engine owns the write port for the whole run
   assign st_we    = busy_o ? eng_we    : acc_we_i;
   assign st_waddr = busy_o ? eng_addr  : acc_addr_i;
   assign st_wdata = busy_o ? eng_wdata : acc_wdata_i;

   inv_mut_store #(.DEPTH(MAX_NODES), .DATA_W(NODE_W)) u_store (
      .clk       (clk),
      .we_i      (st_we),
      .waddr_i   (st_waddr),
      .wdata_i   (st_wdata),
      .raddr_a_i (eng_addr),
      .rdata_a_o (eng_rdata),
      .raddr_b_i (acc_addr_i),
      .rdata_b_o (acc_rdata_o)
   );

endmodule

// File: tb/inv_mut_unit_test.sv
module inv_mut_unit_test;

   localparam int          MAXN  = 32;
   localparam int          NW    = 7;
   localparam int          LW    = $clog2(MAXN+1);
   localparam int          AW    = $clog2(MAXN);
   localparam logic [15:0] SEEDV = 16'hACE1;
   localparam int unsigned THR   = 32768;

   localparam int NTBL = 14;
   localparam int TBL_LEN [NTBL] = '{2, 3, 4, 5, 8, 9, 16, 17, 31, 32, 40, 63, 1, 0};
   localparam int TBL_PAT [NTBL] = '{3, 5, 7, 11, 13, 1, 9, 17, 19, 23, 29, 31, 37, 41};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [LW-1:0] len_i = '0;
   logic          acc_we_i = 1'b0;
   logic [AW-1:0] acc_addr_i = '0;
   logic [NW-1:0] acc_wdata_i = '0;
   logic [NW-1:0] acc_rdata_o;
   logic          busy_o, done_o, mutated_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int n_mut  = 0;

   logic [15:0]   m_rng;
   logic [NW-1:0] m_tour [MAXN];

   always #5 clk = ~clk;

   inv_mut_unit #(
      .MAX_NODES  (MAXN),
      .NODE_W     (NW),
      .SEED       (SEEDV),
      .MUT_THRESH (THR)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .len_i       (len_i),
      .acc_we_i    (acc_we_i),
      .acc_addr_i  (acc_addr_i),
      .acc_wdata_i (acc_wdata_i),
      .acc_rdata_o (acc_rdata_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .mutated_o   (mutated_o)
   );

   function automatic logic [15:0] adv(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   task automatic check(input string tag, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic load_tour(input int pat, input int ofs);
      for (int i = 0; i < MAXN; i++) begin
         @(negedge clk);
         acc_we_i    = 1'b1;
         acc_addr_i  = AW'(i);
         acc_wdata_i = NW'(i * pat + ofs);
         m_tour[i]   = NW'(i * pat + ofs);
      end
      @(negedge clk);
      acc_we_i = 1'b0;
   endtask

   task automatic check_tour(input string tag);
      int bad = -1;
      int act = 0;
      for (int i = 0; i < MAXN; i++) begin
         acc_addr_i = AW'(i);
         #1;
         if (bad < 0 && acc_rdata_o !== m_tour[i]) begin
            bad = i;
            act = int'(acc_rdata_o);
         end
      end
      checks++;
      if (bad >= 0) begin
         fails++;
         $display("FAIL %s tour entry %0d: actual %0d expected %0d",
                  tag, bad, act, m_tour[bad]);
      end
   endtask

   // one run: model (R2 R3 R4 R5 R6), then compare latency, flags and contents
   task automatic run_trial(input int len, input bit intrude);
      int eff, a, b, lo, hi, k, exp_lat, lat;
      bit exp_mut;
      logic [NW-1:0] t;
      logic [NW-1:0] guard;
      string tag;
      eff = (len > MAXN) ? MAXN : len;
      tag = (len > MAXN) ? "R4" : "R6";
      m_rng   = adv(m_rng);
      exp_lat = 1;
      exp_mut = 1'b0;
      if (eff >= 2 && int'(m_rng) < int'(THR)) begin
         m_rng = adv(m_rng);
         a = int'(m_rng) % eff;
         m_rng = adv(m_rng);
         b = int'(m_rng) % eff;
         lo = (a < b) ? a : b;
         hi = (a < b) ? b : a;
         exp_lat = 3;
         if (lo != hi) begin
            k = (hi - lo + 1) / 2;
            exp_lat = 3 + 4 * k;
            exp_mut = 1'b1;
            while (lo < hi) begin
               t = m_tour[lo]; m_tour[lo] = m_tour[hi]; m_tour[hi] = t;
               lo++; hi--;
            end
         end
      end
      guard = m_tour[MAXN-1];
      @(negedge clk);
      len_i   = LW'(len);
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      // R9 busy after accept
      check("R9 busy after start", int'(busy_o), 1);
      if (intrude) begin
         // R8 write and start while busy must be ignored
         acc_we_i    = 1'b1;
         acc_addr_i  = AW'(MAXN-1);
         acc_wdata_i = ~guard;
         start_i     = 1'b1;
      end
      lat = 0;
      while (!done_o && lat < 300) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         acc_we_i = 1'b0;
         start_i  = 1'b0;
      end
      check($sformatf("R7 latency len=%0d", len), lat, exp_lat);
      check($sformatf("%s mutated flag len=%0d", exp_mut ? "R6" : "R5", len),
            int'(mutated_o), int'(exp_mut));
      @(posedge clk);
      @(negedge clk);
      check("R7 done single cycle", int'(done_o), 0);
      check("R9 idle after done", int'(busy_o), 0);
      // R10 flag held while idle
      check("R10 flag held", int'(mutated_o), int'(exp_mut));
      if (exp_mut) n_mut++;
      if (intrude) check_tour("R8 busy write ignored");
      else if (eff < 2) check_tour("R3 short tour");
      else check_tour($sformatf("%s R2 len=%0d", tag, len));
   endtask

   initial begin
      m_rng = SEEDV;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1 busy after reset", int'(busy_o), 0);
      check("R1 done after reset", int'(done_o), 0);
      check("R1 mutated after reset", int'(mutated_o), 0);
      rst_n = 1'b1;

      for (int r = 0; r < 6; r++) begin
         for (int e = 0; e < NTBL; e++) begin
            load_tour(TBL_PAT[e], r * 3 + e);
            run_trial(TBL_LEN[e], 1'b0);
         end
      end

      // directed: host write and start strobe during a run (R8, R2 continuity)
      load_tour(5, 1);
      run_trial(4, 1'b1);
      load_tour(7, 2);
      run_trial(MAXN, 1'b0);
      load_tour(3, 9);
      run_trial(1, 1'b0);

      $display("Mutating runs seen: %0d", n_mut);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule